// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block is the write-only configuration port of a frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a load strobe. While the load strobe is low, each rising serial-clock edge shifts one data bit into a 19-bit register. The most significant bit goes first, so the last bit received is a control bit. When the load strobe rises, the register contents are copied into one of two holding sets, and the control bit picks which one. The reference set holds a 14-bit reference divide ratio and four mode flags: prescaler select, phase polarity, monitor-output select and charge-pump current select. The divider set holds a 7-bit swallow count and an 11-bit main count.

The three serial wires are sampled in the system clock domain. A registered edge detector feeds a three-state controller. In `ST_IDLE` the controller waits for a load-strobe rising edge and then goes to `ST_XFER`. In `ST_XFER` it copies the word for one cycle and then goes to `ST_HOLD` without any condition. In `ST_HOLD` it stays until the load strobe is seen low again, and then returns to `ST_IDLE`. Each holding set has a one-cycle update strobe that tells the divider and comparator logic that new fields are present.

Top module: `synth_prog_port`

## Requirements
- R1: While `rst_n` is low, every latched field and both update strobes are zero.
- R2: While `ser_le` is low, each rising edge of `ser_clk` shifts `ser_data` into a 19-bit register, most significant bit first. The last bit received ends in word position 1, which is the control bit.
- R3: When the control bit is 1, the load writes the reference set. Word positions 2..15 become `ref_ratio`, with the LSB at position 2. Position 16 becomes `presc_sel`, 17 becomes `phase_inv`, 18 becomes `mon_sel` and 19 becomes `cp_hi`.
- R4: When the control bit is 0, the load writes the divider set. Word positions 2..8 become `swallow`, with the LSB at position 2. Positions 9..19 become `main_cnt`, with the LSB at position 9.
- R5: A load leaves the holding set it did not select unchanged.
- R6: Rising `ser_clk` edges while `ser_le` is high do not change the shift register.
- R7: A transfer does not clear the shift register. A second `ser_le` rise with no new bits in between writes the same word again.
- R8: Each load raises exactly one strobe for exactly one system clock cycle: `ref_upd` for the reference set, `div_upd` for the divider set. The two strobes are never high together.
- R9: A `ser_le` rise that is set up before system clock edge k makes the new fields and the strobe visible after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; low while shifting, rising edge transfers |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_sel | output | 1 | Prescaler modulus select flag |
| phase_inv | output | 1 | Phase comparator polarity flag |
| mon_sel | output | 1 | Monitor output select flag |
| cp_hi | output | 1 | Charge-pump current select flag |
| swallow | output | 7 | Swallow count |
| main_cnt | output | 11 | Main programmable count |
| ref_upd | output | 1 | One-cycle pulse when the reference set is written |
| div_upd | output | 1 | One-cycle pulse when the divider set is written |

## Verification
A controller stuck outside `ST_IDLE` shows up at the first following load: no strobe appears, or a strobe repeats on a later edge. The bench catches this within three system clocks of the `ser_le` rise. A shift register that drops, duplicates or misorders a bit shows as a wrong field bit after the next transfer. Walking a single one through all 19 positions under both control values points to the exact bit. A wrong destination decode shows as a corrupted field in the holding set that should not have changed, and the bench compares that set after every load.

// File: rtl/spp_pkg.sv
package spp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } spp_state_t;

    localparam int FLAG_N = 4;
endpackage

// File: rtl/spp_front.sv
module spp_front #(
    parameter int SR_W = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_le,
    output logic            le_lvl,
    output logic            le_rise,
    output logic [SR_W-1:0] sr
);
    logic clk_q, clk_p, dat_q, le_p;
    logic shift_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            clk_p  <= 1'b0;
            dat_q  <= 1'b0;
            le_lvl <= 1'b0;
            le_p   <= 1'b0;
        end else begin
            clk_q  <= ser_clk;
            clk_p  <= clk_q;
            dat_q  <= ser_data;
            le_lvl <= ser_le;
            le_p   <= le_lvl;
        end
    end

    assign le_rise  = le_lvl & ~le_p;
    assign shift_en = clk_q & ~clk_p & ~le_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '0;
        else if (shift_en)
            sr <= {sr[SR_W-2:0], dat_q};
    end
endmodule

// File: rtl/spp_fsm.sv
module spp_fsm
    import spp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_lvl,
    input  logic le_rise,
    output logic xfer
);
    spp_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        xfer     = 1'b0;
        unique case (state)
            ST_IDLE: if (le_rise) state_nx = ST_XFER;
            ST_XFER: begin
                xfer     = 1'b1;
                state_nx = ST_HOLD;
            end
            ST_HOLD: if (!le_lvl) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/spp_latch.sv
module spp_latch #(
    parameter int REF_W  = 14,
    parameter int SWAL_W = 7,
    parameter int MAIN_W = 11,
    parameter int FLAG_N = 4,
    localparam int SR_W  = 1 + REF_W + FLAG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SR_W-1:0]   sr,
    input  logic              xfer,
    output logic [REF_W-1:0]  ref_ratio,
    output logic [FLAG_N-1:0] flags,
    output logic [SWAL_W-1:0] swallow,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              ref_upd,
    output logic              div_upd
);
    logic sel_ref;
    assign sel_ref = sr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio <= '0;
            ref_upd   <= 1'b0;
        end else begin
            ref_upd <= xfer & sel_ref;
            if (xfer && sel_ref)
                ref_ratio <= sr[REF_W:1];
        end
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (xfer && sel_ref)
                flags[g] <= sr[REF_W+1+g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swallow  <= '0;
            main_cnt <= '0;
            div_upd  <= 1'b0;
        end else begin
            div_upd <= xfer & ~sel_ref;
            if (xfer && !sel_ref) begin
                swallow  <= sr[SWAL_W:1];
                main_cnt <= sr[SWAL_W+MAIN_W:SWAL_W+1];
            end
        end
    end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import spp_pkg::*;
#(
    parameter int REF_W  = 14,
    parameter int SWAL_W = 7,
    parameter int MAIN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              phase_inv,
    output logic              mon_sel,
    output logic              cp_hi,
    output logic [SWAL_W-1:0] swallow,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              ref_upd,
    output logic              div_upd
);
    localparam int SR_W = 1 + REF_W + FLAG_N;

    logic            le_lvl, le_rise, xfer;
    logic [SR_W-1:0] sr;
    logic [FLAG_N-1:0] flags;

    spp_front #(.SR_W(SR_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .le_lvl(le_lvl), .le_rise(le_rise), .sr(sr)
    );

    spp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .le_lvl(le_lvl), .le_rise(le_rise), .xfer(xfer)
    );

    spp_latch #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .FLAG_N(FLAG_N)) u_latch (
        .clk(clk), .rst_n(rst_n), .sr(sr), .xfer(xfer),
        .ref_ratio(ref_ratio), .flags(flags), .swallow(swallow), .main_cnt(main_cnt),
        .ref_upd(ref_upd), .div_upd(div_upd)
    );

    assign presc_sel = flags[0];
    assign phase_inv = flags[1];
    assign mon_sel   = flags[2];
    assign cp_hi     = flags[3];
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
    parameter int REF_W  = 14,
    parameter int SWAL_W = 7,
    parameter int MAIN_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_le,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              presc_sel,
    input logic              phase_inv,
    input logic              mon_sel,
    input logic              cp_hi,
    input logic [SWAL_W-1:0] swallow,
    input logic [MAIN_W-1:0] main_cnt,
    input logic              ref_upd,
    input logic              div_upd
);
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd && div_upd));

    assert_ref_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd);

    assert_div_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_upd |=> !div_upd);

    assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> ($stable(ref_ratio) && $stable(presc_sel) && $stable(phase_inv)
                      && $stable(mon_sel) && $stable(cp_hi)));

    assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !div_upd |-> ($stable(swallow) && $stable(main_cnt)));

    assert_strobe_after_le_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd || div_upd) |-> $past(ser_le, 3));
endmodule

bind synth_prog_port synth_prog_port_chk #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_le(ser_le), .ref_ratio(ref_ratio),
    .presc_sel(presc_sel), .phase_inv(phase_inv), .mon_sel(mon_sel), .cp_hi(cp_hi),
    .swallow(swallow), .main_cnt(main_cnt), .ref_upd(ref_upd), .div_upd(div_upd)
);

// File: tb/synth_prog_port_bench.sv
module synth_prog_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic presc_sel, phase_inv, mon_sel, cp_hi;
    logic [6:0]  swallow;
    logic [10:0] main_cnt;
    logic ref_upd, div_upd;

    int n_chk = 0, n_err = 0;
    logic [31:0] e_ref = 0, e_flg = 0, e_swal = 0, e_main = 0;

    always #2 clk = ~clk;

    synth_prog_port u_synth_prog_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .presc_sel(presc_sel), .phase_inv(phase_inv),
        .mon_sel(mon_sel), .cp_hi(cp_hi), .swallow(swallow), .main_cnt(main_cnt),
        .ref_upd(ref_upd), .div_upd(div_upd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] flg_now();
        return {28'd0, cp_hi, mon_sel, phase_inv, presc_sel};
    endfunction

    task automatic chk_fields(input string req);
        chk(ref_ratio == e_ref[13:0], req, ref_ratio, e_ref);
        chk(flg_now() == e_flg, req, flg_now(), e_flg);
        chk(swallow == e_swal[6:0], req, swallow, e_swal);
        chk(main_cnt == e_main[10:0], req, main_cnt, e_main);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R2: MSB first, control bit last
    task automatic send_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) begin
            ser_data = w[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
    endtask

    // R3 R4 R5 R8 R9: timed load with arithmetic expected fields
    task automatic do_load(input logic [18:0] w, input bit keep_high);
        @(posedge clk); #1;
        ser_le = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(!ref_upd && !div_upd, "R9 early strobe", {ref_upd, div_upd}, 0);
        chk_fields("R9 early fields");
        if (w[0]) begin
            e_ref = (w >> 1) & 32'h3FFF;
            e_flg = (w >> 15) & 32'hF;
        end else begin
            e_swal = (w >> 1) & 32'h7F;
            e_main = (w >> 8) & 32'h7FF;
        end
        @(posedge clk); @(negedge clk);
        chk(ref_upd == w[0] && div_upd == !w[0], "R8 strobe", {ref_upd, div_upd}, {w[0], !w[0]});
        chk_fields(w[0] ? "R3/R5 ref load" : "R4/R5 div load");
        @(posedge clk); @(negedge clk);
        chk(!ref_upd && !div_upd, "R8 single pulse", {ref_upd, div_upd}, 0);
        tick(3);
        if (!keep_high) begin
            ser_le = 1'b0;
            tick(4);
        end
    endtask

    initial begin
        tick(3);
        @(negedge clk);
        chk({ref_ratio, presc_sel, phase_inv, mon_sel, cp_hi, swallow, main_cnt} == 0, "R1 reset fields",
            {ref_ratio, swallow, main_cnt}, 0);
        chk(!ref_upd && !div_upd, "R1 reset strobes", {ref_upd, div_upd}, 0);
        rst_n = 1'b1;
        tick(3);

        // R2 R3 R4: walking one through every position, both destinations
        for (int c = 0; c < 2; c++) begin
            for (int b = 1; b < 19; b++) begin
                logic [18:0] w;
                w = (19'd1 << b) | 19'(c);
                send_word(w);
                do_load(w, 1'b0);
            end
        end
        // dense arithmetic patterns
        for (int k = 0; k < 6; k++) begin
            logic [18:0] w;
            w = 19'((k * 32'h2D4B3 + 32'h15A5A) & 32'h7FFFF);
            send_word(w);
            do_load(w, 1'b0);
            send_word(w ^ 19'h1);
            do_load(w ^ 19'h1, 1'b0);
        end
        send_word(19'h7FFFF); do_load(19'h7FFFF, 1'b0);
        send_word(19'h7FFFE); do_load(19'h7FFFE, 1'b0);

        // R7: reload without new bits rewrites the same word
        send_word(19'h2B6C9);
        do_load(19'h2B6C9, 1'b0);
        do_load(19'h2B6C9, 1'b1);

        // R6: clock edges while ser_le high are ignored
        for (int i = 0; i < 19; i++) begin
            ser_data = ~i[0];
            tick(3); ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(2);
        end
        ser_le = 1'b0;
        tick(4);
        do_load(19'h2B6C9, 1'b0);
        chk(ref_ratio == 14'((19'h2B6C9 >> 1) & 19'h3FFF), "R6 shift frozen", ref_ratio, 14'((19'h2B6C9 >> 1) & 19'h3FFF));

        // R1: asynchronous reset mid-run
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        chk({ref_ratio, presc_sel, phase_inv, mon_sel, cp_hi, swallow, main_cnt} == 0, "R1 async reset",
            {ref_ratio, swallow, main_cnt}, 0);
        tick(2);
        rst_n = 1'b1;
        tick(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++; n_err++;
        $display("FAIL watchdog act=1 exp=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule